// File: doc/BRIEF.md
# Set/Clear Interrupt Enable and Priority Register Bank

This block is a small bank of memory-mapped interrupt control registers. Each register is given a set address, a clear address, or both. A register with both addresses is a shared value reached through two aliases. Writing to the set alias turns bits on. Writing to the clear alias turns bits off. A register with only one address takes the written word as its new value. Address decode looks at the low 29 bits of the bus address only, so aliases that differ in the top three bits reach the same register.

Each register is split into equal-width fields. One-bit fields act as per-source enables. Wider fields act as per-source priority levels. After every accepted write, the block compares each field's old and new contents. For each field that differs, it emits one event. The event names the source tied to that field and says whether the field is now nonzero (enable) or zero (disable). A downstream interrupt core consumes these events to update its own gating.

The event output is a valid/ready stream. An event is held steady until the consumer takes it. While any event from the last write is still waiting, the register port deasserts its write-ready and drops writes, so back-pressure on the event stream stalls the bus.

Top module: `setclr_mask_bank`

## Requirements
- R1: A register is selected when bits 28:0 of `bus_addr` equal bits 28:0 of its configured set or clear address; bits 31:29 are ignored. A configured address of zero means that alias is absent and matches nothing.
- R2: For a register with both a set and a clear address, a write to the set address stores the old value OR `bus_wdata`.
- R3: For a register with both a set and a clear address, a write to the clear address stores the old value AND NOT `bus_wdata`.
- R4: For a register with only one address (set-only or clear-only), a write stores `bus_wdata` unchanged.
- R5: A register of width DW with field width FW has DW/FW fields. A field width of 1 gives per-bit enables, and a wider field holds a priority level.
- R6: Field k occupies bits [(DW/FW-1-k)*FW +: FW]. Events from one write leave in increasing k, which is from the most significant field downward. Field k reports the source index configured in slot k of that register.
- R7: A field whose contents do not change produces no event. A changed field produces an event with `evt_en`=1 if its new contents are nonzero, and `evt_en`=0 if they are zero.
- R8: At most one event is offered per clock. While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_src` and `evt_en` hold their values. Each cycle with both high retires exactly one event.
- R9: `bus_wready` is low from the cycle after a write that produced events until the last of those events is taken. A write presented while `bus_wready` is low is dropped.
- R10: `bus_rdata` returns the stored value of the register selected by `bus_addr` (through any of its aliases). An unmatched address reads zero, and a write to it changes nothing and produces no event.
- R11: Reset clears every register to zero, discards any pending events, and produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Register address for read and write |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write request, taken when `bus_wready` is high |
| bus_wready | output | 1 | High when a write will be accepted |
| bus_rdata | output | DW | Stored value at `bus_addr`, zero when unmatched |
| evt_valid | output | 1 | Event offered |
| evt_ready | input | 1 | Consumer takes the offered event |
| evt_src | output | SW | Source index of the event |
| evt_en | output | 1 | 1 = enable, 0 = disable |

## Verification
The hardest condition to reach is a bus write that lands while events from an earlier write are still queued. Only a stalled event consumer opens that window. The stimulus holds `evt_ready` low after a multi-field write, presents a clearing write during the stall, and then checks two things: the queued event stays frozen, and the stored value is unchanged once the stream drains. A reset applied while a six-event burst is stalled covers discarding pending events. A vector table walks the two alias merges, the replace mode and a priority register where one field changes value without changing state. It also covers the high-bit alias and writes to unmatched addresses, including address zero.

// File: rtl/smr_pkg.sv
package smr_pkg;

  // How a decoded write combines with the stored value
  typedef enum logic [1:0] {
    MD_NONE  = 2'd0,
    MD_SET   = 2'd1,
    MD_CLR   = 2'd2,
    MD_PLAIN = 2'd3
  } wmode_e;

endpackage

// File: rtl/smr_decode.sv
module smr_decode
  import smr_pkg::*;
#(
  parameter int          NREG = 3,
  parameter int          IW   = 2,
  parameter logic [31:0] SET_ADDR [NREG] = '{default: 32'h0},
  parameter logic [31:0] CLR_ADDR [NREG] = '{default: 32'h0}
) (
  input  logic [31:0]   addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output wmode_e        mode
);

  localparam int AW = 29;

  logic unused_hi;
  assign unused_hi = ^addr[31:AW];

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    mode = MD_NONE;
    // scan downward so the lowest-numbered register wins a clash
    for (int r = NREG - 1; r >= 0; r--) begin
      logic has_s, has_c, m_s, m_c;
      has_s = SET_ADDR[r][AW-1:0] != '0;
      has_c = CLR_ADDR[r][AW-1:0] != '0;
      m_s   = has_s && (addr[AW-1:0] == SET_ADDR[r][AW-1:0]);
      m_c   = has_c && (addr[AW-1:0] == CLR_ADDR[r][AW-1:0]);
      if (m_s || m_c) begin
        hit = 1'b1;
        idx = IW'(r);
        if (has_s && has_c) mode = m_s ? MD_SET : MD_CLR;
        else                mode = MD_PLAIN;
      end
    end
  end

endmodule

// File: rtl/smr_evscan.sv
module smr_evscan #(
  parameter int NREG = 3,
  parameter int DW   = 8,
  parameter int SW   = 5,
  parameter int IW   = 2,
  parameter int FIELD_W [NREG]     = '{default: 1},
  parameter int SRC_MAP [NREG][DW] = '{default: '{default: 0}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  output logic          busy,
  output logic          evt_valid,
  input  logic          evt_ready,
  output logic [SW-1:0] evt_src,
  output logic          evt_en
);

  localparam int KW = (DW > 1) ? $clog2(DW) : 1;

  logic [NREG*DW-1:0] chg_flat, en_flat;
  logic [DW-1:0]      pend_q, val_q, chg_sel, en_sel;
  logic [IW-1:0]      ridx_q;
  logic [KW-1:0]      sel;

  // per-register field compare, field k counted from the top
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int FW = FIELD_W[r];
    localparam int NF = DW / FW;
    logic [DW-1:0] chg_r, en_r;
    always_comb begin
      chg_r = '0;
      en_r  = '0;
      for (int k = 0; k < NF; k++) begin
        chg_r[k] = old_val[(NF-1-k)*FW +: FW] != new_val[(NF-1-k)*FW +: FW];
        en_r[k]  = |val_q[(NF-1-k)*FW +: FW];
      end
    end
    assign chg_flat[r*DW +: DW] = chg_r;
    assign en_flat[r*DW +: DW]  = en_r;
  end

  assign chg_sel = chg_flat[load_idx*DW +: DW];
  assign en_sel  = en_flat[ridx_q*DW +: DW];

  // lowest pending slot number goes first
  always_comb begin
    sel = '0;
    for (int k = DW - 1; k >= 0; k--)
      if (pend_q[k]) sel = KW'(k);
  end

  assign evt_valid = |pend_q;
  assign busy      = evt_valid;
  assign evt_en    = en_sel[sel];
  assign evt_src   = SW'(SRC_MAP[ridx_q][sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ridx_q <= '0;
      val_q  <= '0;
    end else if (load) begin
      pend_q <= chg_sel;
      ridx_q <= load_idx;
      val_q  <= new_val;
    end else if (evt_valid && evt_ready) begin
      pend_q[sel] <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_src) && $stable(evt_en));

  assert_one_per_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready |=> $countones(pend_q) + 1 == $past($countones(pend_q)));

endmodule

// File: rtl/setclr_mask_bank.sv
module setclr_mask_bank
  import smr_pkg::*;
#(
  parameter int          NREG = 3,
  parameter int          DW   = 8,
  parameter int          SW   = 5,
  parameter logic [31:0] SET_ADDR [NREG] = '{32'h0000_0100, 32'h0000_0000, 32'h0000_010C},
  parameter logic [31:0] CLR_ADDR [NREG] = '{32'h0000_0104, 32'h0000_0108, 32'h0000_0000},
  parameter int          FIELD_W  [NREG] = '{1, 1, 4},
  parameter int          SRC_MAP  [NREG][DW] = '{'{0, 1, 2, 3, 4, 5, 6, 7},
                                                 '{8, 9, 10, 11, 12, 13, 14, 15},
                                                 '{16, 17, 0, 0, 0, 0, 0, 0}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic          bus_wready,
  output logic [DW-1:0] bus_rdata,
  output logic          evt_valid,
  input  logic          evt_ready,
  output logic [SW-1:0] evt_src,
  output logic          evt_en
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic               hit, busy, wr_fire;
  logic [IW-1:0]      idx;
  wmode_e             mode;
  logic [DW-1:0]      old_val, new_val;
  logic [NREG*DW-1:0] bank_q;

  smr_decode #(
    .NREG(NREG), .IW(IW), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx), .mode(mode)
  );

  always_comb begin
    old_val = bank_q[idx*DW +: DW];
    unique case (mode)
      MD_SET:  new_val = old_val | bus_wdata;
      MD_CLR:  new_val = old_val & ~bus_wdata;
      default: new_val = bus_wdata;
    endcase
  end

  assign bus_wready = !busy;
  assign wr_fire    = bus_we && bus_wready && hit;
  assign bus_rdata  = hit ? old_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       bank_q <= '0;
    else if (wr_fire) bank_q[idx*DW +: DW] <= new_val;
  end

  smr_evscan #(
    .NREG(NREG), .DW(DW), .SW(SW), .IW(IW), .FIELD_W(FIELD_W), .SRC_MAP(SRC_MAP)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .load(wr_fire), .load_idx(idx),
    .old_val(old_val), .new_val(new_val), .busy(busy),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src), .evt_en(evt_en)
  );

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wready |=> $stable(bank_q));

  assert_miss_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !hit |=> $stable(bank_q) && !$rose(evt_valid));

  assert_no_change_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_wready && hit && (new_val == old_val) |=> !evt_valid);

endmodule

// File: tb/tb_setclr_mask_bank.sv
module tb_setclr_mask_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        bus_wready;
  logic [7:0]  bus_rdata;
  logic        evt_valid;
  logic        evt_ready;
  logic [4:0]  evt_src;
  logic        evt_en;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setclr_mask_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_wready(bus_wready), .bus_rdata(bus_rdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src), .evt_en(evt_en)
  );

  typedef struct packed {
    logic [31:0] wa;
    logic [7:0]  wd;
    logic [31:0] ra;
    logic [7:0]  rexp;
    logic [3:0]  cnt;
    logic [4:0]  fsrc;
    logic        fen;
    logic [4:0]  lsrc;
    logic        len;
  } vec_t;

  // reg0: set 0x100 / clear 0x104, 1-bit fields, sources 0..7
  // reg1: clear-only 0x108, 1-bit fields, sources 8..15
  // reg2: set-only 0x10C, 4-bit fields, sources 16,17
  localparam vec_t TBL [12] = '{
    '{32'h100,       8'h81, 32'h100,       8'h81, 4'd2, 5'd0,  1'b1, 5'd7,  1'b1}, // R2 R6
    '{32'h100,       8'h01, 32'h100,       8'h81, 4'd0, 5'd0,  1'b0, 5'd0,  1'b0}, // R7 no change
    '{32'h104,       8'h80, 32'h104,       8'h01, 4'd1, 5'd0,  1'b0, 5'd0,  1'b0}, // R3
    '{32'h2000_0100, 8'h06, 32'h2000_0100, 8'h07, 4'd2, 5'd5,  1'b1, 5'd6,  1'b1}, // R1 alias
    '{32'h108,       8'hF0, 32'h108,       8'hF0, 4'd4, 5'd8,  1'b1, 5'd11, 1'b1}, // R4 clear-only
    '{32'h108,       8'h30, 32'h108,       8'h30, 4'd2, 5'd8,  1'b0, 5'd9,  1'b0}, // R4 R7
    '{32'h10C,       8'h35, 32'h10C,       8'h35, 4'd2, 5'd16, 1'b1, 5'd17, 1'b1}, // R5
    '{32'h10C,       8'h36, 32'h10C,       8'h36, 4'd1, 5'd17, 1'b1, 5'd17, 1'b1}, // R5 level change
    '{32'h10C,       8'h06, 32'h10C,       8'h06, 4'd1, 5'd16, 1'b0, 5'd16, 1'b0}, // R5 R7
    '{32'h200,       8'hFF, 32'h200,       8'h00, 4'd0, 5'd0,  1'b0, 5'd0,  1'b0}, // R10 miss
    '{32'h104,       8'hFF, 32'h100,       8'h00, 4'd3, 5'd5,  1'b0, 5'd7,  1'b0}, // R3 R6
    '{32'h0,         8'hFF, 32'h108,       8'h30, 4'd0, 5'd0,  1'b0, 5'd0,  1'b0}  // R1 zero absent
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic collect(output int n, output logic [4:0] fs, output logic fe,
                         output logic [4:0] ls, output logic le);
    n = 0; fs = '0; fe = 1'b0; ls = '0; le = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!evt_valid) break;
      if (n == 0) begin fs = evt_src; fe = evt_en; end
      ls = evt_src; le = evt_en; n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string req, input logic [31:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, int'(bus_rdata), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic [4:0] fs, ls;
    logic fe, le;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; evt_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 valid after reset", int'(evt_valid), 0);
    chk("R9 wready after reset", int'(bus_wready), 1);
    read_chk("R11 reg0 reset", 32'h100, 8'h00);
    read_chk("R11 reg1 reset", 32'h108, 8'h00);
    read_chk("R11 reg2 reset", 32'h10C, 8'h00);

    // table walk
    for (int v = 0; v < 12; v++) begin
      do_write(TBL[v].wa, TBL[v].wd);
      collect(n, fs, fe, ls, le);
      chk($sformatf("R7 vec%0d event count", v), n, int'(TBL[v].cnt));
      chk($sformatf("R6 vec%0d first src", v), int'(fs), int'(TBL[v].fsrc));
      chk($sformatf("R7 vec%0d first en", v), int'(fe), int'(TBL[v].fen));
      chk($sformatf("R6 vec%0d last src", v), int'(ls), int'(TBL[v].lsrc));
      chk($sformatf("R7 vec%0d last en", v), int'(le), int'(TBL[v].len));
      chk($sformatf("R9 vec%0d wready after drain", v), int'(bus_wready), 1);
      read_chk($sformatf("R10 vec%0d readback", v), TBL[v].ra, TBL[v].rexp);
    end

    // back-pressure: reg0 is 0x00; set 0xC0 gives src0 then src1
    evt_ready = 1'b0;
    do_write(32'h100, 8'hC0);
    chk("R8 valid under stall", int'(evt_valid), 1);
    chk("R9 wready low while queued", int'(bus_wready), 0);
    chk("R6 first held src", int'(evt_src), 0);
    do_write(32'h104, 8'hFF); // must be dropped
    @(negedge clk);
    chk("R8 src held through stall", int'(evt_src), 0);
    chk("R8 en held through stall", int'(evt_en), 1);
    read_chk("R9 dropped write left reg0", 32'h100, 8'hC0);
    evt_ready = 1'b1;
    collect(n, fs, fe, ls, le);
    chk("R8 stalled burst count", n, 2);
    chk("R6 stalled burst last src", int'(ls), 1);
    chk("R9 wready after stalled drain", int'(bus_wready), 1);
    read_chk("R9 reg0 after drain", 32'h100, 8'hC0);

    // reset with a six-event burst pending (reg1 0x30 -> 0xFF)
    evt_ready = 1'b0;
    do_write(32'h108, 8'hFF);
    chk("R9 busy before reset", int'(bus_wready), 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 pending discarded", int'(evt_valid), 0);
    chk("R11 wready after reset", int'(bus_wready), 1);
    read_chk("R11 reg0 cleared", 32'h100, 8'h00);
    read_chk("R11 reg1 cleared", 32'h108, 8'h00);
    read_chk("R11 reg2 cleared", 32'h10C, 8'h00);
    evt_ready = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule